// File: doc/BRIEF.md
# Dual-Alias Page Security Gate

This block sits on the path between an interconnect port and a single memory device. The memory is mapped twice in the system address space: once in a Non-secure window and once in a Secure window. Address bit 28 picks the window. The gate removes that bit to form the physical word address. It then looks up a one-bit security attribute for the 1 KB page that is being addressed. Every page is usable through exactly one of the two windows. An access through the other window never reaches the memory and is reported as an error.

Secure software reprograms the page attributes at run time through a separate configuration port. The port accepts only writes that carry the Secure flag. Changing an attribute moves a page from one domain to the other without copying any data, because both windows reach the same physical words. The lookup and the permit decision are combinational, so an allowed access is issued to the memory in the same cycle as the request. The read data and the error flag come back registered, one cycle later, in step with a block-RAM style memory.

Top module: `mag_top`

## Requirements
- R1: The memory word index is req_addr[15:2]. Address bit 28 selects the window (0 = Non-secure, 1 = Secure). All other address bits have no effect, so 0x00001404 and 0x10001404 reach the same word when their page permits it.
- R2: The attribute table holds 64 one-bit entries, indexed by req_addr[15:10]. Attribute 1 means Non-secure and 0 means Secure. Reset clears every entry to Secure.
- R3: A Secure-window request to a Secure page, and a Non-secure-window request to a Non-secure page, both drive mem_en high in the same cycle. mem_we follows req_write.
- R4: A Secure-window request to a Non-secure page is blocked. mem_en stays low and the response data is all zeros.
- R5: A Non-secure-window request to a Secure page is blocked in the same way.
- R6: A blocked write leaves the memory contents unchanged.
- R7: rsp_err is high for exactly the one cycle after each blocked request, and is low at every other time.
- R8: A configuration write with cfg_we=1 and cfg_secure=1 sets entry cfg_idx to cfg_ns, with effect from the next cycle. A configuration write with cfg_secure=0 is ignored.
- R9: rsp_valid is high in the cycle after each request. rsp_rdata carries the memory word after an allowed read and is zero after a write, after a blocked request, and when rsp_valid is low.
- R10: Flipping a page's attribute keeps its data. A word written through one window can be read through the other window once the page has been moved to that window's domain.
- R11: A request that arrives in the same cycle as a configuration write to its page is decided using the attribute value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address, including the window bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero unless an allowed read |
| rsp_err | output | 1 | Previous request was blocked |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_secure | input | 1 | Security flag of the attribute write |
| cfg_idx | input | 6 | Page being reprogrammed |
| cfg_ns | input | 1 | New attribute, 1 = Non-secure |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Physical word index |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_en |

## Verification
The bench targets several corner cases, and each one would expose a specific fault. Cross-window visibility: a gate that kept bit 28 in the physical address would send the two windows to different words, so data written through one window would not appear in the other. Stale read data after a blocked read: a gate that only withheld the memory enable would return the memory's previous output instead of zeros. Ignored Non-secure configuration writes: a gate that accepted them would let Non-secure software take over Secure pages. A configuration write in the same cycle as a request to the same page: a gate that decided on the new attribute would let that request through one cycle early. The bench also checks the first and last pages, and random garbage in the unused address bits, which a gate with the wrong slice would not ignore.

// File: rtl/mag_pkg.sv
package mag_pkg;

  typedef enum logic {
    WIN_NONSEC = 1'b0,
    WIN_SEC    = 1'b1
  } win_e;

  typedef struct packed {
    logic valid;
    logic write;
    logic blocked;
  } req_stat_t;

  // A page is reachable only through the window that matches its attribute.
  function automatic logic win_permits(win_e win, logic page_ns);
    return (win == WIN_SEC) ? ~page_ns : page_ns;
  endfunction

endpackage

// File: rtl/mag_attr_table.sv
module mag_attr_table #(
  parameter int NUM_PAGES = 64,
  parameter int IDX_W     = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_secure,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_ns,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_ns
);

  logic [NUM_PAGES-1:0] attr_q;
  logic                 upd;

  assign upd = cfg_we & cfg_secure;

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q <= '0;
    end else if (upd) begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (cfg_idx == IDX_W'(p)) begin
          attr_q[p] <= cfg_ns;
        end
      end
    end
  end

  generate
    if (NUM_PAGES == (1 << IDX_W)) begin : g_full
      assign lk_ns = attr_q[lk_idx];
    end else begin : g_partial
      logic in_range;
      assign in_range = ({{(32-IDX_W){1'b0}}, lk_idx} < 32'(NUM_PAGES));
      assign lk_ns    = in_range ? attr_q[lk_idx] : 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mag_decode.sv
module mag_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BIT  = 28,
  parameter int PAGE_LSB = 10,
  parameter int IDX_W    = 6,
  parameter int BYTE_LSB = 2
) (
  input  logic [ADDR_W-1:0]                  req_addr,
  output mag_pkg::win_e                      win,
  output logic [IDX_W-1:0]                   page_idx,
  output logic [PAGE_LSB+IDX_W-BYTE_LSB-1:0] word_addr
);

  localparam int OFS_TOP = PAGE_LSB + IDX_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] USED_MASK =
    (((ONE << OFS_TOP) - ONE) & ~((ONE << BYTE_LSB) - ONE)) | (ONE << WIN_BIT);

  logic [ADDR_W-1:0] spare_bits;
  logic              unused_spare;

  assign win       = mag_pkg::win_e'(req_addr[WIN_BIT]);
  assign page_idx  = req_addr[OFS_TOP-1:PAGE_LSB];
  assign word_addr = req_addr[OFS_TOP-1:BYTE_LSB];

  assign spare_bits   = req_addr & ~USED_MASK;
  assign unused_spare = ^spare_bits;

endmodule

// File: rtl/mag_gate.sv
module mag_gate #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 14
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  mag_pkg::win_e     win,
  input  logic              page_ns,
  input  logic [MEM_AW-1:0] word_addr,
  output logic              blocked,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic permit;

  always_comb begin
    permit    = mag_pkg::win_permits(win, page_ns);
    blocked   = req_valid & ~permit;
    mem_en    = req_valid & permit;
    mem_we    = req_valid & permit & req_write;
    mem_addr  = word_addr;
    mem_wdata = req_wdata;
  end

endmodule

// File: rtl/mag_resp.sv
module mag_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              blocked,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  mag_pkg::req_stat_t stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q.valid   <= req_valid;
      stat_q.write   <= req_write & req_valid;
      stat_q.blocked <= blocked;
    end
  end

  logic pass_data;

  assign pass_data = stat_q.valid & ~stat_q.write & ~stat_q.blocked;
  assign rsp_valid = stat_q.valid;
  assign rsp_err   = stat_q.blocked;
  assign rsp_rdata = pass_data ? mem_rdata : '0;

endmodule

// File: rtl/mag_top.sv
module mag_top #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_BYTES = 1024,
  parameter int NUM_PAGES  = 64,
  parameter int WIN_BIT    = 28,
  parameter int PAGE_LSB   = $clog2(PAGE_BYTES),
  parameter int IDX_W      = $clog2(NUM_PAGES),
  parameter int BYTE_LSB   = $clog2(DATA_W / 8),
  parameter int MEM_AW     = PAGE_LSB + IDX_W - BYTE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              cfg_we,
  input  logic              cfg_secure,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_ns,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  mag_pkg::win_e     win;
  logic [IDX_W-1:0]  page_idx;
  logic [MEM_AW-1:0] word_addr;
  logic              page_ns;
  logic              blocked;

  mag_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_BIT (WIN_BIT),
    .PAGE_LSB(PAGE_LSB),
    .IDX_W   (IDX_W),
    .BYTE_LSB(BYTE_LSB)
  ) decode_i (
    .req_addr (req_addr),
    .win      (win),
    .page_idx (page_idx),
    .word_addr(word_addr)
  );

  mag_attr_table #(
    .NUM_PAGES(NUM_PAGES),
    .IDX_W    (IDX_W)
  ) table_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_secure(cfg_secure),
    .cfg_idx   (cfg_idx),
    .cfg_ns    (cfg_ns),
    .lk_idx    (page_idx),
    .lk_ns     (page_ns)
  );

  mag_gate #(
    .DATA_W(DATA_W),
    .MEM_AW(MEM_AW)
  ) gate_i (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_wdata(req_wdata),
    .win      (win),
    .page_ns  (page_ns),
    .word_addr(word_addr),
    .blocked  (blocked),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  mag_resp #(
    .DATA_W(DATA_W)
  ) resp_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .blocked  (blocked),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
  );

endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_PAGES = 64,
  parameter int WIN_BIT   = 28,
  parameter int PAGE_LSB  = 10,
  parameter int IDX_W     = 6,
  parameter int BYTE_LSB  = 2,
  parameter int MEM_AW    = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              cfg_we,
  input logic              cfg_secure,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic              cfg_ns,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr
);

  logic [NUM_PAGES-1:0] shadow_ns;
  logic [IDX_W-1:0]     pg;
  logic                 model_ok;
  logic                 unused_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_ns <= '0;
    end else if (cfg_we && cfg_secure) begin
      shadow_ns[cfg_idx] <= cfg_ns;
    end
  end

  assign pg          = req_addr[PAGE_LSB+IDX_W-1:PAGE_LSB];
  assign model_ok    = req_addr[WIN_BIT] ? !shadow_ns[pg] : shadow_ns[pg];
  assign unused_addr = ^req_addr;

  AST_PASS_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    req_valid && model_ok |-> mem_en); // R3
  AST_BLOCK_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    req_valid && !model_ok |-> !mem_en); // R5
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en && req_write); // R6
  AST_WORD_INDEX: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> mem_addr == req_addr[PAGE_LSB+IDX_W-1:BYTE_LSB]); // R1
  AST_ERR_AFTER_BLOCK: assert property (@(posedge clk) disable iff (rst)
    req_valid && !model_ok |=> rsp_err); // R7
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid)); // R7
  AST_ZERO_ON_BLOCK: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == '0); // R4
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rsp_rdata == '0 && !rsp_err); // R9

endmodule

bind mag_top mag_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_PAGES(NUM_PAGES),
  .WIN_BIT  (WIN_BIT),
  .PAGE_LSB (PAGE_LSB),
  .IDX_W    (IDX_W),
  .BYTE_LSB (BYTE_LSB),
  .MEM_AW   (MEM_AW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .cfg_we    (cfg_we),
  .cfg_secure(cfg_secure),
  .cfg_idx   (cfg_idx),
  .cfg_ns    (cfg_ns),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/mag_top_tb_top.sv
`timescale 1ns/1ps
module mag_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        cfg_we, cfg_secure, cfg_ns;
  logic [5:0]  cfg_idx;
  logic        mem_en, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem_model [16384];
  logic [31:0] ref_mem   [16384];
  logic [63:0] ref_ns;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mag_top dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cfg_we(cfg_we), .cfg_secure(cfg_secure), .cfg_idx(cfg_idx), .cfg_ns(cfg_ns),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_model[mem_addr] <= mem_wdata;
      mem_rdata <= mem_model[mem_addr];
    end
  end

  function automatic bit win_ok(bit sec, bit ns);
    return sec ? !ns : ns;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    cfg_we = 0; cfg_secure = 0; cfg_idx = '0; cfg_ns = 0;
  endtask

  // One request and/or one configuration write, then check the response.
  task automatic op(bit dr, bit wr, logic [31:0] a, logic [31:0] wd,
                    bit dc, bit cs, int ci, bit cn, string tag);
    bit ok;
    int pg, w;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = dr; req_write = wr; req_addr = a; req_wdata = wd;
    cfg_we = dc; cfg_secure = cs; cfg_idx = 6'(ci); cfg_ns = cn;
    pg  = int'(a[15:10]);
    w   = int'(a[15:2]);
    ok  = dr && win_ok(a[28], ref_ns[pg]);
    exp = (ok && !wr) ? ref_mem[w] : 32'h0;
    #1;
    check(mem_en == ok, {tag, " mem_en"}, 32'(mem_en), 32'(ok));
    check(mem_we == (ok && wr), {tag, " mem_we"}, 32'(mem_we), 32'(ok && wr));
    if (ok && wr) ref_mem[w] = wd;
    if (dc && cs) ref_ns[ci] = cn;
    @(negedge clk);
    drive_idle();
    #1;
    check(rsp_valid == dr, {tag, " rsp_valid"}, 32'(rsp_valid), 32'(dr));
    check(rsp_err == (dr && !ok), {tag, " rsp_err"}, 32'(rsp_err), 32'(dr && !ok));
    check(rsp_rdata == exp, {tag, " rsp_rdata"}, rsp_rdata, exp);
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    #1;
    check(!rsp_valid && !rsp_err && rsp_rdata == 0, tag,
          {rsp_valid, rsp_err, rsp_rdata[29:0]}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0A11));
    for (int i = 0; i < 16384; i++) begin
      mem_model[i] = '0;
      ref_mem[i]   = '0;
    end
    ref_ns = '0;
    drive_idle();
    rst = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(!rsp_valid && !rsp_err && rsp_rdata == 0, "R2 R9 reset outputs",
          {rsp_valid, rsp_err, rsp_rdata[29:0]}, 32'h0);

    // R2 R5: table resets Secure, so the Non-secure window is blocked
    op(1, 0, 32'h0000_1400, 0, 0, 0, 0, 0, "R2 R5 ns read after reset");
    idle_check("R7 err is a single pulse");
    // R3 R1: Secure window to Secure page
    op(1, 1, 32'h1000_1404, 32'hA5A5_0001, 0, 0, 0, 0, "R3 secure write");
    op(1, 0, 32'h1000_1404, 0, 0, 0, 0, 0, "R1 R3 secure read");
    // R8: Non-secure config write is ignored
    op(0, 0, 0, 0, 1, 0, 5, 1, "R8 ns cfg write");
    op(1, 0, 32'h1000_1404, 0, 0, 0, 0, 0, "R8 page still secure");
    // R8 R10: flip page 5 to Non-secure, data kept
    op(0, 0, 0, 0, 1, 1, 5, 1, "R8 secure cfg write");
    op(1, 0, 32'h0000_1404, 0, 0, 0, 0, 0, "R1 R10 ns window sees data");
    op(1, 0, 32'h1000_1404, 0, 0, 0, 0, 0, "R4 secure read of ns page");
    // R6: blocked write does not land
    op(1, 1, 32'h1000_1404, 32'hDEAD_BEEF, 0, 0, 0, 0, "R4 R6 blocked write");
    op(1, 0, 32'h0000_1404, 0, 0, 0, 0, 0, "R6 memory unchanged");
    // R10: write via Non-secure, move page back, read via Secure
    op(1, 1, 32'h0000_1408, 32'h1234_5678, 0, 0, 0, 0, "R3 ns write");
    op(0, 0, 0, 0, 1, 1, 5, 0, "R8 back to secure");
    op(1, 0, 32'h1000_1408, 0, 0, 0, 0, 0, "R10 secure window sees data");
    // R1: unused upper bits ignored
    op(1, 0, 32'hEFFF_1408, 0, 0, 0, 0, 0, "R1 garbage upper bits");
    // R11: same-cycle reprogramming uses the old attribute
    op(1, 0, 32'h0000_1C00, 0, 1, 1, 7, 1, "R11 same cycle old value");
    op(1, 0, 32'h0000_1C00, 0, 0, 0, 0, 0, "R11 new value next cycle");
    // Boundary pages
    op(0, 0, 0, 0, 1, 1, 63, 1, "R8 last page ns");
    op(1, 1, 32'h0000_FFFC, 32'hCAFE_F00D, 0, 0, 0, 0, "R3 last page write");
    op(1, 0, 32'h1000_FFFC, 0, 0, 0, 0, 0, "R4 last page secure read");
    op(1, 0, 32'h0000_FFFC, 0, 0, 0, 0, 0, "R3 last page ns read");
    op(1, 1, 32'h0000_0000, 32'h0BAD_0BAD, 0, 0, 0, 0, "R5 first page ns write");
    op(1, 0, 32'h1000_0000, 0, 0, 0, 0, 0, "R6 first page unchanged");

    for (int i = 0; i < 500; i++) begin
      int pg, wsel, cpg;
      logic [31:0] a;
      bit dr, dc;
      pg   = ($urandom % 9 == 8) ? 63 : int'($urandom % 8);
      wsel = int'($urandom % 4);
      a    = $urandom & 32'hEFFF_0000;
      a   |= ({31'h0, 1'($urandom)} << 28) | (32'(pg) << 10) | (32'(wsel) << 2);
      dr   = ($urandom % 8) != 0;
      dc   = ($urandom % 4) == 0;
      cpg  = ($urandom % 2) ? pg : int'($urandom % 8);
      op(dr, 1'($urandom), a, $urandom, dc, 1'($urandom), cpg, 1'($urandom),
         "R3 R4 R5 R6 R7 R9 R11 random");
    end
    idle_check("R9 idle after random");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule